// File: doc/BRIEF.md
# Byte-Wide Bus SPI Master with Transfer FIFOs

This block is a full-duplex SPI master that a processor drives through an 8-bit Wishbone slave port. Software pushes bytes into a four-entry transmit queue. The master shifts each byte out on the serial data output and, in the same cell times, captures the serial data input into a four-entry receive queue. Software then pops the received bytes through the same data register. Clock polarity, clock phase, bit order, the serial clock rate and eight slave-select lines are all set through registers. An interrupt can be raised after every 1, 2, 3 or 4 completed bytes.

A three-state shifter sequences each byte. SH_IDLE waits for work and takes the IDLE→LEAD transition when the block is enabled, the transmit queue holds a byte and the receive queue has room. On that transition it pops the byte. SH_LEAD is the first half of a bit cell. At the end of its half period it samples the input and takes LEAD→TRAIL. SH_TRAIL is the second half of the cell. At the end of its half period it shifts the next bit out and takes TRAIL→LEAD, or after bit 7 it pushes the received byte and takes TRAIL→IDLE. SH_IDLE always lasts at least one cycle between bytes. Only the serial clock level in each state depends on the mode, so the sample and shift points stay the same in all four modes.

Registers, on a 3-bit word address:
- 0 is control: bit0 enable, bit1 clock polarity, bit2 clock phase, bit3 LSB-first, bit4 interrupt enable, bits 6:5 byte count minus one.
- 1 is status.
- 2 is data.
- 3 is the half-period divider.
- 4 is slave select.

Top module: `spim_top`

## Requirements
- R1: Each bus access is acknowledged by a single-cycle pulse on `wb_ack_o` in the cycle after `wb_stb_i` is seen, and the control, divider and select registers read back the value last written.
- R2: After reset, status reads 0x05, `irq_o` and `wb_ack_o` are low, `sck_o` is 0 and every `ss_n_o` line is high.
- R3: Each queue holds 4 bytes. Status bit0 is receive-empty, bit1 is receive-full, bit2 is transmit-empty and bit3 is transmit-full.
- R4: A write of data while the transmit queue is full, or a read of data while the receive queue is empty, sets the sticky error flag in status bit5 and leaves the queue contents unchanged. Writing 1 to bit5 clears the flag.
- R5: With no byte in flight, `sck_o` equals the polarity bit. With phase 0, input bits are sampled on the leading clock edge. With phase 1, they are sampled on the trailing edge, and the output changes on the opposite edge.
- R6: With control bit3 at 0 the byte goes out MSB first, and with bit3 at 1 it goes out LSB first. Received bits are assembled in the same order.
- R7: Every transmitted byte yields one received byte, and the received bytes are read from the data register in transfer order.
- R8: Each half of a serial clock period lasts divider+1 system clock cycles.
- R9: `ss_n_o[i]` is the inverse of select register bit i.
- R10: Status bit7 is set after every N completed bytes, where N is control bits 6:5 plus one. A write to control restarts the count. Writing 1 to bit7 clears the flag. `irq_o` is the flag ANDed with control bit4.
- R11: Status bit4 (busy) is 1 while a byte is shifting.
- R12: No byte starts while control bit0 is 0 or the receive queue is full. A stalled byte starts once a received byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Register word address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data |
| wb_ack_o | output | 1 | Access acknowledge |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | SS_WIDTH | Active-low slave selects |

## Verification
Writes take effect on the rising edge that raises the acknowledge, and read data is valid with the acknowledge, so the bench drives on falling edges and samples one falling edge later. The status flags, the received byte and the interrupt flag all change on the edge where the last half cell ends, which is the same edge where busy falls. The bench therefore polls status until busy is low before it checks the interrupt or reads data. A slave model watches the serial clock on falling system edges and samples the data output only on the edge its mode calls for. The divider check counts rising system edges between two consecutive serial clock changes inside one byte.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_LEAD  = 2'd1,
        SH_TRAIL = 2'd2
    } sh_state_t;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_DATA = 3'd2;
    localparam logic [2:0] A_DIV  = 3'd3;
    localparam logic [2:0] A_SSEL = 3'd4;

    localparam int C_EN   = 0;
    localparam int C_CPOL = 1;
    localparam int C_CPHA = 2;
    localparam int C_LSB  = 3;
    localparam int C_IE   = 4;

    localparam int S_ERR  = 5;
    localparam int S_IRQ  = 7;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= step(wp_q);
            if (pop)  rp_q <= step(rp_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= wdata;
    end

    assign rdata = mem[rp_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int DIVW = 8,
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            cpol,
    input  logic            cpha,
    input  logic            lsb_first,
    input  logic [DIVW-1:0] half_div,
    input  logic            tx_empty,
    input  logic            rx_full,
    input  logic [BITS-1:0] tx_byte,
    output logic            tx_pop,
    output logic            rx_push,
    output logic [BITS-1:0] rx_byte,
    output logic            busy,
    output logic            sck_o,
    output logic            mosi_o,
    input  logic            miso_i
);
    localparam int BW = $clog2(BITS);

    sh_state_t       st_q, st_d;
    logic [DIVW-1:0] tick_q;
    logic [BW-1:0]   bit_q;
    logic [BITS-1:0] txsh_q, rxsh_q;
    logic            half_end, can_start, last_bit;

    assign half_end  = (tick_q == half_div);
    assign can_start = en & ~tx_empty & ~rx_full;
    assign last_bit  = (bit_q == BW'(BITS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SH_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SH_IDLE:  if (can_start) st_d = SH_LEAD;
            SH_LEAD:  if (half_end)  st_d = SH_TRAIL;
            SH_TRAIL: if (half_end)  st_d = last_bit ? SH_IDLE : SH_LEAD;
            default:  st_d = SH_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            bit_q  <= '0;
            txsh_q <= '0;
            rxsh_q <= '0;
        end else begin
            if (st_q == SH_IDLE || half_end) tick_q <= '0;
            else                             tick_q <= tick_q + 1'b1;
            if (tx_pop) begin
                txsh_q <= tx_byte;
                bit_q  <= '0;
            end
            if (st_q == SH_LEAD && half_end)
                rxsh_q <= lsb_first ? {miso_i, rxsh_q[BITS-1:1]} : {rxsh_q[BITS-2:0], miso_i};
            if (st_q == SH_TRAIL && half_end) begin
                txsh_q <= lsb_first ? (txsh_q >> 1) : (txsh_q << 1);
                bit_q  <= bit_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            SH_LEAD:  sck_o = cpol ^ cpha;
            SH_TRAIL: sck_o = ~(cpol ^ cpha);
            default:  sck_o = cpol;
        endcase
        tx_pop  = (st_q == SH_IDLE) && can_start;
        rx_push = (st_q == SH_TRAIL) && half_end && last_bit;
        busy    = (st_q != SH_IDLE);
        mosi_o  = lsb_first ? txsh_q[0] : txsh_q[BITS-1];
        rx_byte = rxsh_q;
    end

    assert_busy_after_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> busy);
    assert_halt_on_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !tx_pop);
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int SS_WIDTH   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wb_cyc_i,
    input  logic                wb_stb_i,
    input  logic                wb_we_i,
    input  logic [2:0]          wb_adr_i,
    input  logic [7:0]          wb_dat_i,
    output logic [7:0]          wb_dat_o,
    output logic                wb_ack_o,
    output logic                irq_o,
    output logic                sck_o,
    output logic                mosi_o,
    input  logic                miso_i,
    output logic [SS_WIDTH-1:0] ss_n_o
);
    localparam int DIVW = 8;

    logic [7:0] ctrl_q, div_q, ssel_q, rdat_q;
    logic       err_q, irq_q, ack_q;
    logic [1:0] done_cnt_q;
    logic       req, wr_acc, rd_acc;
    logic       tx_push, tx_pop, tx_empty, tx_full;
    logic       rx_push, rx_pop, rx_empty, rx_full;
    logic [7:0] tx_rdata, rx_rdata, rx_wdata, stat;
    logic       busy, bad_wr, bad_rd;

    assign req     = wb_cyc_i & wb_stb_i & ~ack_q;
    assign wr_acc  = req & wb_we_i;
    assign rd_acc  = req & ~wb_we_i;
    assign bad_wr  = wr_acc && wb_adr_i == A_DATA && tx_full;
    assign bad_rd  = rd_acc && wb_adr_i == A_DATA && rx_empty;
    assign tx_push = wr_acc && wb_adr_i == A_DATA && !tx_full;
    assign rx_pop  = rd_acc && wb_adr_i == A_DATA && !rx_empty;
    assign stat    = {irq_q, 1'b0, err_q, busy, tx_full, tx_empty, rx_full, rx_empty};

    spim_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .wdata(wb_dat_i), .rdata(tx_rdata), .empty(tx_empty), .full(tx_full));

    spim_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .wdata(rx_wdata), .rdata(rx_rdata), .empty(rx_empty), .full(rx_full));

    spim_shift #(.DIVW(DIVW), .BITS(8)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[C_EN]), .cpol(ctrl_q[C_CPOL]),
        .cpha(ctrl_q[C_CPHA]), .lsb_first(ctrl_q[C_LSB]), .half_div(div_q),
        .tx_empty(tx_empty), .rx_full(rx_full), .tx_byte(tx_rdata),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_wdata), .busy(busy),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            div_q      <= '0;
            ssel_q     <= '0;
            rdat_q     <= '0;
            err_q      <= 1'b0;
            irq_q      <= 1'b0;
            ack_q      <= 1'b0;
            done_cnt_q <= '0;
        end else begin
            ack_q <= req;
            if (wr_acc) begin
                unique case (wb_adr_i)
                    A_CTRL: ctrl_q <= wb_dat_i;
                    A_DIV:  div_q  <= wb_dat_i;
                    A_SSEL: ssel_q <= wb_dat_i;
                    A_STAT: begin
                        if (wb_dat_i[S_ERR]) err_q <= 1'b0;
                        if (wb_dat_i[S_IRQ]) irq_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (bad_wr || bad_rd) err_q <= 1'b1;
            if (wr_acc && wb_adr_i == A_CTRL) begin
                done_cnt_q <= '0;
            end else if (rx_push) begin
                if (done_cnt_q == ctrl_q[6:5]) begin
                    done_cnt_q <= '0;
                    irq_q      <= 1'b1;
                end else begin
                    done_cnt_q <= done_cnt_q + 1'b1;
                end
            end
            if (rd_acc) begin
                unique case (wb_adr_i)
                    A_CTRL:  rdat_q <= ctrl_q;
                    A_STAT:  rdat_q <= stat;
                    A_DATA:  rdat_q <= rx_empty ? 8'h00 : rx_rdata;
                    A_DIV:   rdat_q <= div_q;
                    A_SSEL:  rdat_q <= ssel_q;
                    default: rdat_q <= 8'h00;
                endcase
            end
        end
    end

    assign wb_dat_o = rdat_q;
    assign wb_ack_o = ack_q;
    assign irq_o    = irq_q & ctrl_q[C_IE];
    assign ss_n_o   = ~ssel_q[SS_WIDTH-1:0];

    assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |=> !wb_ack_o);
    assert_irq_needs_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_q && !rx_push) |=> !irq_q);
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(wr_acc && wb_adr_i == A_STAT && wb_dat_i[S_ERR])) |=> err_q);
endmodule

// File: tb/spim_top_test.sv
module spim_top_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cyc = 0, stb = 0, we = 0;
    logic [2:0] adr = 0;
    logic [7:0] dat_i = 0;
    logic [7:0] dat_o;
    logic       ack, irq, sck, mosi, miso;
    logic [7:0] ss_n;

    always #5 clk = ~clk;   // 100 MHz nominal

    spim_top uut (
        .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(dat_i), .wb_dat_o(dat_o), .wb_ack_o(ack),
        .irq_o(irq), .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .ss_n_o(ss_n));

    int checks = 0, errors = 0, ack_late = 0;
    logic [7:0] q_mosi[$], q_reply[$], q_rx[$];
    bit b_cpol = 0, b_cpha = 0, b_lsb = 0;
    string tag = "R5";

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // slave model: scoreboard monitor for the serial side
    int n = 0, nbytes = 0;
    bit have = 0;
    logic [7:0] cur = 0, cap = 0;
    logic prev_sck = 0;
    assign miso = have ? (b_lsb ? cur[n] : cur[7-n]) : 1'b0;

    always @(negedge clk) begin
        if (ss_n[0] == 1'b0 && sck !== prev_sck) begin
            if ((sck !== b_cpol) ^ b_cpha) begin
                if (b_lsb) cap[n] = mosi; else cap[7-n] = mosi;
                if (n == 7) begin
                    n = 0; have = 0; nbytes++;
                    if (q_mosi.size() == 0) chk({tag, " unexpected byte"}, cap, 0);
                    else chk({tag, " serial byte"}, cap, q_mosi.pop_front());
                end else n++;
            end
        end
        prev_sck = sck;
        if (!have && q_reply.size() > 0) begin cur = q_reply.pop_front(); have = 1; end
    end

    task automatic wb_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); cyc = 1; stb = 1; we = 1; adr = a; dat_i = d;
        @(negedge clk); if (!ack) ack_late++;
        while (!ack) @(negedge clk);
        cyc = 0; stb = 0; we = 0;
    endtask

    task automatic wb_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); cyc = 1; stb = 1; we = 0; adr = a;
        @(negedge clk); if (!ack) ack_late++;
        while (!ack) @(negedge clk);
        d = dat_o; cyc = 0; stb = 0;
    endtask

    task automatic send(input logic [7:0] tx, input logic [7:0] rep);
        q_mosi.push_back(tx); q_reply.push_back(rep); q_rx.push_back(rep);
        wb_wr(3'd2, tx);
    endtask

    task automatic rd_rx(input string req);
        logic [7:0] d;
        wb_rd(3'd2, d);
        chk(req, d, q_rx.pop_front());
    endtask

    task automatic cfg(input logic [7:0] c);
        wb_wr(3'd4, 8'h00);
        b_cpol = c[1]; b_cpha = c[2]; b_lsb = c[3];
        wb_wr(3'd0, c);
        wb_wr(3'd4, 8'h01);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            wb_rd(3'd1, s);
            if ((s & 8'h14) == 8'h04) return;
        end
        chk("R11 idle timeout", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog", 0, 1);
        finish_sim();
    end

    initial begin
        logic [7:0] s;
        int base, cnt;
        logic v;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 reset state
        chk("R2 ack", ack, 0); chk("R2 irq", irq, 0);
        chk("R2 ss_n", ss_n, 8'hFF); chk("R2 sck", sck, 0);
        wb_rd(3'd1, s); chk("R2 status", s, 8'h05);
        // R1 / R9 registers
        wb_wr(3'd4, 8'h5A); chk("R9 ss_n", ss_n, 8'hA5);
        wb_rd(3'd4, s); chk("R1 select readback", s, 8'h5A);
        wb_wr(3'd3, 8'h01); wb_rd(3'd3, s); chk("R1 divider readback", s, 8'h01);
        // mode 0, MSB first
        tag = "R5 R6 mode0 msb"; cfg(8'h01);
        wb_rd(3'd0, s); chk("R1 control readback", s, 8'h01);
        send(8'hA5, 8'h5A);
        wb_rd(3'd1, s); chk("R11 busy", s[4], 1);
        send(8'h3C, 8'hC3); send(8'hF0, 8'h0F);
        wait_idle();
        rd_rx("R7 rx0"); rd_rx("R7 rx1"); rd_rx("R7 rx2");
        // mode 3, LSB first
        tag = "R5 R6 mode3 lsb"; cfg(8'h0F);
        chk("R5 idle high", sck, 1);
        send(8'h81, 8'h18); send(8'h4E, 8'hE4);
        wait_idle(); rd_rx("R6 rx lsb0"); rd_rx("R6 rx lsb1");
        // mode 1, MSB; mode 2, LSB
        tag = "R5 mode1"; cfg(8'h05); send(8'h6B, 8'hD2); wait_idle(); rd_rx("R5 rx mode1");
        tag = "R5 mode2"; cfg(8'h0B); chk("R5 idle high m2", sck, 1);
        send(8'h1D, 8'hB8); wait_idle(); rd_rx("R5 rx mode2");
        // R8 divider
        tag = "R8 div"; cfg(8'h01); wb_wr(3'd3, 8'h04);
        send(8'h3C, 8'h81);
        @(sck); v = sck; cnt = 0;
        do begin @(posedge clk); cnt++; #1; end while (sck == v && cnt < 100);
        chk("R8 half period", cnt, 5);
        wait_idle(); rd_rx("R8 rx"); wb_wr(3'd3, 8'h01);
        // R10 interrupt after 2 bytes
        tag = "R10"; cfg(8'h31); wb_wr(3'd1, 8'h80);
        send(8'h11, 8'h22); wait_idle(); chk("R10 irq after 1 of 2", irq, 0);
        send(8'h33, 8'h44); wait_idle(); chk("R10 irq after 2 of 2", irq, 1);
        wb_rd(3'd1, s); chk("R10 status flag", s[7], 1);
        wb_wr(3'd1, 8'h80); chk("R10 cleared", irq, 0);
        rd_rx("R10 rx"); rd_rx("R10 rx");
        // R10 after 4 bytes
        cfg(8'h71);
        send(8'h01, 8'h10); wait_idle(); send(8'h02, 8'h20); wait_idle();
        send(8'h03, 8'h30); wait_idle(); chk("R10 irq after 3 of 4", irq, 0);
        send(8'h04, 8'h40); wait_idle(); chk("R10 irq after 4 of 4", irq, 1);
        wb_wr(3'd1, 8'h80);
        rd_rx("R10 rx"); rd_rx("R10 rx"); rd_rx("R10 rx"); rd_rx("R10 rx");
        // R10 gating by enable bit
        cfg(8'h01); send(8'h55, 8'hAA); wait_idle();
        chk("R10 irq gated", irq, 0);
        wb_rd(3'd1, s); chk("R10 flag without enable", s[7], 1);
        wb_wr(3'd1, 8'h80); rd_rx("R10 rx");
        // R3 R4 R12 queues
        tag = "R4 queue"; cfg(8'h00); wb_wr(3'd1, 8'hA0);
        send(8'hC1, 8'h1C); send(8'hC2, 8'h2C); send(8'hC3, 8'h3C); send(8'hC4, 8'h4C);
        repeat (20) @(negedge clk);
        wb_rd(3'd1, s); chk("R12 disabled holds, R3 tx full", s & 8'h3F, 8'h09);
        wb_wr(3'd2, 8'h77);
        wb_rd(3'd1, s); chk("R4 overflow error", s & 8'h3F, 8'h29);
        wb_wr(3'd1, 8'h20);
        wb_rd(3'd1, s); chk("R4 error cleared", s & 8'h3F, 8'h09);
        base = nbytes;
        wb_wr(3'd0, 8'h01);
        wait_idle();
        chk("R4 only four bytes sent", nbytes - base, 4);
        chk("R4 scoreboard drained", q_mosi.size(), 0);
        wb_rd(3'd1, s); chk("R3 rx full", s & 8'h3F, 8'h06);
        send(8'h99, 8'h66);
        repeat (40) @(negedge clk);
        wb_rd(3'd1, s); chk("R12 stalled on rx full", s & 8'h3F, 8'h02);
        chk("R12 no byte", nbytes - base, 4);
        rd_rx("R7 rx order");
        wait_idle();
        chk("R12 resumed", nbytes - base, 5);
        rd_rx("R7 rx order"); rd_rx("R7 rx order"); rd_rx("R7 rx order"); rd_rx("R7 rx order");
        wb_rd(3'd2, s);
        wb_rd(3'd1, s); chk("R4 underflow error", s & 8'h3F, 8'h25);
        wb_wr(3'd1, 8'h20);
        chk("R1 ack timing", ack_late, 0);
        chk("R7 rx queue drained", q_rx.size(), 0);
        finish_sim();
    end
endmodule